// File: doc/BRIEF.md
# Interconnect Deadlock Timeout Monitor

This block sits beside an interconnect and watches every master that has a request in flight. Each master has its own wait counter. The counter advances on every bus clock cycle in which the master has an outstanding request and no response arrives. When a counter reaches the programmed timeout, that master is treated as deadlocked. Fabric-side transaction tracking and any recovery action are handled elsewhere.

On a deadlock the block sets a raw interrupt bit. It also records the number of the lowest-indexed master that timed out in that cycle. While the raw bit stays set, that code is held. Software reaches the timeout value, the status code and the interrupt registers through a small word-addressed register bus. Writes are single-cycle and reads are combinational. The interrupt output is the raw bit masked by an enable bit.

Register map (word address on `bus_addr`):

- 0: timeout.
- 1: status.
- 2: raw.
- 3: masked status.
- 4: enable.
- 5: clear.

Top module: `deadlock_watch`

## Requirements
- R1: After reset, the timeout register (address 0, bits 12:0) reads 2048, the enable register (address 4, bit 0) reads 1, the raw register (address 2, bit 0) reads 0, the status register (address 1) reads 0 and `irq` is low.
- R2: A master's wait counter returns to zero in any cycle in which its response pulse is high or its pending input is low. As a result, a master that receives a response at least once every timeout cycles never raises a deadlock.
- R3: Let a master hold pending high with no response from cycle s onward. Its wait count is k in cycle s+k. The master is expired in any cycle where the count is at least the timeout value. In the clock edge that ends an expired cycle, the raw bit is set.
- R4: The status register holds the captured master code in bits 3:0. This code is the lowest index among the masters that were expired in the capturing cycle. Bit 4 of the status register reads the current raw bit.
- R5: Writing address 5 with bit 0 set clears the raw bit. Writing address 5 with bit 0 zero has no effect. Address 5 always reads 0, and so do unmapped addresses 6 and 7.
- R6: When a clear write and an expired master occur in the same cycle, the raw bit stays set.
- R7: The master code is captured only in a cycle where the raw bit is clear or a clear write occurs. While the raw bit stays set, later deadlocks leave the code unchanged.
- R8: `irq` and bit 0 of the masked status register (address 3) both equal raw AND enable. Writing address 4 bit 0 updates the enable bit.
- R9: Writing address 0 loads bits 12:0 of the write data into the timeout register. Bits 31:13 of the timeout register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_pending | input | NUM_MST | Per-master level: a request is outstanding |
| mst_resp | input | NUM_MST | Per-master pulse: a response arrived this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Masked deadlock interrupt |

## Verification
The hardest situation to reach from the ports is a clear write that lands in the very cycle a master is expired. The same stimulus also covers a second master timing out while the code is frozen. The bench keeps two masters stalled past the timeout, with the lower one starting later, so that both stay expired. It then issues the clear. Its behavioural model predicts that the raw bit survives and that the code is recaptured to the lower index. Responses arriving just inside the timeout window and two masters expiring in the same cycle are covered by dedicated phases.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned CODE_W = 4;

  localparam logic [REG_AW-1:0] ADR_LIMIT  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_STATUS = 3'd1;
  localparam logic [REG_AW-1:0] ADR_RAW    = 3'd2;
  localparam logic [REG_AW-1:0] ADR_MASKED = 3'd3;
  localparam logic [REG_AW-1:0] ADR_ENABLE = 3'd4;
  localparam logic [REG_AW-1:0] ADR_CLEAR  = 3'd5;

  // lowest set bit of a 16-bit vector, 0 when empty
  function automatic logic [CODE_W-1:0] first_hit(input logic [15:0] v);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 15; i >= 0; i--) begin
      if (v[i]) r = CODE_W'(i);
    end
    return r;
  endfunction

  // wait count after one cycle, saturating
  function automatic logic [31:0] wait_step(input logic [31:0] cnt, input logic [31:0] top,
                                            input logic restart);
    if (restart) return 32'd0;
    if (cnt == top) return cnt;
    return cnt + 32'd1;
  endfunction
endpackage

// File: rtl/dlw_timer.sv
module dlw_timer #(
  parameter int unsigned CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic          resp,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  import dlw_pkg::*;

  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic [CW-1:0] wait_cnt;
  logic          restart;
  logic [31:0]   nxt_wide;

  assign restart  = !pending || resp;
  assign nxt_wide = wait_step(32'(wait_cnt), 32'(CNT_TOP), restart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else        wait_cnt <= nxt_wide[CW-1:0];
  end

  assign expired = pending && !resp && (wait_cnt >= limit);

  // R2: a response or an idle master restarts the count
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (wait_cnt == '0));

  // R3: a stalled master advances by one per cycle until saturation
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && wait_cnt != CNT_TOP) |=> (wait_cnt == $past(wait_cnt) + 1'b1));
endmodule

// File: rtl/dlw_pick.sv
module dlw_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] hits,
  output logic         any_hit,
  output logic [3:0]   code
);
  import dlw_pkg::*;

  logic [15:0] wide;
  assign wide    = 16'(hits);
  assign any_hit = |hits;
  assign code    = first_hit(wide);

  // R4: the chosen master is really expired and none below it is
  always_comb begin
    if (any_hit) begin
      a_pick_r4: assert (hits[code] && ((hits & ((N'(1) << code) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/dlw_regs.sv
module dlw_regs #(
  parameter int unsigned CW      = 13,
  parameter int unsigned RST_LIM = 2048
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [dlw_pkg::REG_AW-1:0]    bus_addr,
  input  logic [dlw_pkg::REG_DW-1:0]    bus_wdata,
  output logic [dlw_pkg::REG_DW-1:0]    bus_rdata,
  input  logic                          dl_event,
  input  logic [3:0]                    dl_code,
  output logic [CW-1:0]                 limit,
  output logic                          irq
);
  import dlw_pkg::*;

  logic       raw_q, en_q;
  logic [3:0] code_q;
  logic       clr_hit, capture;

  assign clr_hit = bus_wr && (bus_addr == ADR_CLEAR) && bus_wdata[0];
  assign capture = dl_event && (!raw_q || clr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit  <= CW'(RST_LIM);
      en_q   <= 1'b1;
      raw_q  <= 1'b0;
      code_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADR_LIMIT)  limit <= bus_wdata[CW-1:0];
      if (bus_wr && bus_addr == ADR_ENABLE) en_q  <= bus_wdata[0];
      if (dl_event)     raw_q <= 1'b1;
      else if (clr_hit) raw_q <= 1'b0;
      if (capture) code_q <= dl_code;
    end
  end

  assign irq = raw_q && en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_LIMIT:  bus_rdata = REG_DW'(limit);
      ADR_STATUS: bus_rdata = REG_DW'({raw_q, code_q});
      ADR_RAW:    bus_rdata = REG_DW'(raw_q);
      ADR_MASKED: bus_rdata = REG_DW'(irq);
      ADR_ENABLE: bus_rdata = REG_DW'(en_q);
      default:    bus_rdata = '0;
    endcase
  end

  // R6: a deadlock event always leaves the raw bit set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dl_event |=> raw_q);

  // R5: a lone clear drops the raw bit
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !dl_event) |=> !raw_q);

  // R7: the code holds while raw stays set without a clear
  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_hit) |=> $stable(code_q));

  // R3: raw rises only after an event
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(dl_event));
endmodule

// File: rtl/deadlock_watch.sv
module deadlock_watch #(
  parameter int unsigned NUM_MST = 4,
  parameter int unsigned CW      = 13,
  parameter int unsigned RST_LIM = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MST-1:0] mst_pending,
  input  logic [NUM_MST-1:0] mst_resp,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq
);
  logic [CW-1:0]      limit;
  logic [NUM_MST-1:0] expired;
  logic               dl_event;
  logic [3:0]         dl_code;

  for (genvar g = 0; g < NUM_MST; g++) begin : g_tmr
    dlw_timer #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (mst_pending[g]),
      .resp    (mst_resp[g]),
      .limit   (limit),
      .expired (expired[g])
    );
  end

  dlw_pick #(.N(NUM_MST)) u_pick (
    .hits    (expired),
    .any_hit (dl_event),
    .code    (dl_code)
  );

  dlw_regs #(.CW(CW), .RST_LIM(RST_LIM)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dl_event  (dl_event),
    .dl_code   (dl_code),
    .limit     (limit),
    .irq       (irq)
  );
endmodule

// File: tb/deadlock_watch_tb.sv
module deadlock_watch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NM-1:0] pend = '0, resp = '0;
  logic          wr = 0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int tests = 0, fails = 0;

  // behavioural reference state
  int m_cnt[NM];
  int m_lim = 2048;
  int m_raw = 0, m_en = 1, m_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadlock_watch #(.NUM_MST(NM)) u_dut (
    .clk(clk), .rst_n(rst_n), .mst_pending(pend), .mst_resp(resp),
    .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  initial foreach (m_cnt[i]) m_cnt[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_lim = 2048; m_raw = 0; m_en = 1; m_code = 0;
    end else begin
      int low;
      bit ev, clr;
      low = -1;
      for (int i = NM - 1; i >= 0; i--)
        if (pend[i] && !resp[i] && m_cnt[i] >= m_lim) low = i;
      ev  = (low >= 0);
      clr = wr && addr == 5 && wdata[0];
      if (ev && (m_raw == 0 || clr)) m_code = low;
      if (ev) m_raw = 1; else if (clr) m_raw = 0;
      for (int i = 0; i < NM; i++)
        if (!pend[i] || resp[i]) m_cnt[i] = 0;
        else if (m_cnt[i] < 8191) m_cnt[i]++;
      if (wr && addr == 0) m_lim = wdata[12:0];
      if (wr && addr == 4) m_en = wdata[0];
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_lim;
      1: return (m_raw << 4) | m_code;
      2: return m_raw;
      3: return m_raw & m_en;
      4: return m_en;
      default: return 0;
    endcase
  endfunction

  // R8: irq compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (irq !== 1'(m_raw & m_en)) begin
        fails++;
        $display("FAIL R8 irq per-cycle: got %0b exp %0d at %0t", irq, m_raw & m_en, $time);
      end
    end
  end

  task automatic rd(input int a, input string tag);
    @(negedge clk); addr = 3'(a); #1;
    tests++;
    if (rdata !== 32'(model_rd(a))) begin
      fails++;
      $display("FAIL %s read addr %0d: got %0h exp %0h", tag, a, rdata, model_rd(a));
    end
  endtask

  task automatic expect_val(input int got, input int exp, input string tag);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk); wr = 1; addr = 3'(a); wdata = 32'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset values
    rd(0, "R1"); expect_val(rdata, 2048, "R1 limit literal");
    rd(4, "R1"); rd(2, "R1"); rd(1, "R1");
    for (int a = 5; a < 8; a++) rd(a, "R5 zero read");
    // R9 timeout width
    wreg(0, 32'hFFFF_FFFF); rd(0, "R9"); expect_val(rdata, 32'h1FFF, "R9 masked");
    wreg(0, 5); rd(0, "R9");
    // R2 responses inside the window keep it quiet
    @(negedge clk); pend[2] = 1;
    for (int k = 0; k < 6; k++) begin
      idle(4); resp[2] = 1; idle(1); resp[2] = 0;
    end
    rd(2, "R2 no deadlock"); expect_val(rdata, 0, "R2 raw literal");
    @(negedge clk); pend[2] = 0; idle(2);
    // R3 continuous stall on master 2
    @(negedge clk); pend[2] = 1;
    idle(5); rd(2, "R3 before");
    idle(2); rd(2, "R3 after"); expect_val(rdata, 1, "R3 raw literal");
    rd(1, "R4 code"); expect_val(rdata, 32'h12, "R4 code literal");
    // R7 master 1 also stalls, code must stay 2
    @(negedge clk); pend[1] = 1; idle(8);
    rd(1, "R7 frozen"); expect_val(rdata[3:0], 2, "R7 code literal");
    // R5 clear with bit0 = 0 ignored
    wreg(5, 32'h2); rd(2, "R5 ignore");
    // R6 clear while both expired: raw stays, code recaptured lowest
    wreg(5, 1); rd(2, "R6 set wins"); rd(1, "R6 recapture");
    expect_val(rdata[3:0], 1, "R6 code literal");
    // R5 real clear
    @(negedge clk); pend = '0; idle(2);
    wreg(5, 1); rd(2, "R5 cleared"); expect_val(rdata, 0, "R5 raw literal");
    rd(1, "R5 status");
    // R8 masking
    wreg(4, 0); rd(4, "R8 en");
    @(negedge clk); pend[3] = 1; idle(8);
    rd(2, "R8 raw"); rd(3, "R8 masked"); expect_val(irq, 0, "R8 irq masked");
    wreg(4, 1); rd(3, "R8 unmasked"); expect_val(irq, 1, "R8 irq");
    @(negedge clk); pend = '0; wreg(5, 1); idle(2);
    // R4 two masters expire in the same cycle
    @(negedge clk); pend = 4'b1001; idle(8);
    rd(1, "R4 same cycle"); expect_val(rdata[3:0], 0, "R4 lowest literal");
    @(negedge clk); pend = '0; wreg(5, 1); idle(2);
    rd(2, "R5 final");
    // R1 reset mid-run
    @(negedge clk); pend = 4'b0100; idle(10); rst_n = 0; idle(2); rst_n = 1;
    pend = '0; rd(0, "R1 re-reset"); rd(2, "R1 re-reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule